// File: doc/BRIEF.md
# Tape Mark-Track Decoder and Timing

This block follows the timing/mark channel of a block-formatted magnetic tape, one frame at a time. Each frame strobe delivers one mark bit. The bit enters a 9-bit sliding window. The top bit of the window is sticky. The window is decoded into one of nine mark codes. Those codes step two one-hot timing shifters. The first, 5 bits wide, times the block-number area. The second, 9 bits wide, times the data-word area. The block pulses every timing bit that rises in a frame. It also keeps a 6-position check ring. With the ring it flags a mark-track error when a mark is missing at a position where one must appear, or when a mark appears at a position where none may.

The frame input is a stream with a valid strobe (`frm_vld`) and no ready. The block accepts every strobe in the cycle it is asserted and never applies back-pressure. A producer may therefore assert the strobe on any cycle, including back-to-back cycles. Nothing changes on cycles without a strobe. A synchronous `clr` returns all state to zero and wins over a strobe in the same cycle.

The decoded mark flags always reflect the current window. The edge vectors and the error are one-cycle pulses. They appear in the cycle after the accepting strobe.

Top module: `tape_mark_timing`

## Requirements
- R1: On a strobe with `wr_timing` low, the window becomes {old bit 8 OR old bit 7, old bits 6..0, `mark_bit`}. Once bit 8 is set, it stays set until a clear or reset.
- R2: `mark_flags` decodes the window (octal values), one bit per code:
  - bit 0: end zone, 0622
  - bit 1: block space, when window AND 0477 equals 0425
  - bit 2: forward block end, 0526
  - bit 3: reverse block end, 0545
  - bit 4: block sync, 0751
  - bit 5: data sync, 0632
  - bit 6: forward data end, 0473 or 0773
  - bit 7: reverse data end, 0410 or 0610
  - bit 8: data, 0470
- R3: Block timing is a 5-bit register. On a block-sync frame it ORs in 020. On a block-sync or block-space frame it then shifts right by one.
- R4: Data timing is a 9-bit register. On a data-sync frame it loads 0400. On a data-sync, forward-data-end or reverse-data-end frame it then shifts right by one.
- R5: `blk_edge` and `dat_edge` pulse, for one cycle after a strobe, the timing bits that are set after that frame and were clear before it.
- R6: The 7-bit check ring shifts right once per non-block-space frame, reloading 0100 first when it holds 1. It is preset to 040 by a block-space frame that leaves block timing bit 0 set.
- R7: Any other frame that leaves block timing bit 0 set enables checking. A block-sync frame disables checking, and wins over the enable.
- R8: When checking was enabled before the frame, `trk_err` pulses if "ring held 040 before the frame" differs from "new window is a mark other than block space or reverse block end".
- R9: A strobe with `wr_timing` high leaves the window (and `mark_flags`) unchanged, while the timing shifters and the ring still advance.
- R10: Reset or `clr` zeroes the window, both timing registers, the ring, the check enable and all outputs.
- R11: Without a strobe, no state changes, and the edge and error outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| frm_vld | input | 1 | Frame strobe; every strobe is accepted |
| mark_bit | input | 1 | Mark-channel bit of this frame |
| wr_timing | input | 1 | Write-timing mode: hold the window |
| mark_flags | output | 9 | Decoded mark codes of the current window (R2 bit map) |
| blk_edge | output | 5 | Rising block-timing bits, one-cycle pulse |
| dat_edge | output | 9 | Rising data-timing bits, one-cycle pulse |
| trk_err | output | 1 | Mark-track error pulse |

## Verification
The assertions assume that `clr` and `rst_n` are the only ways state is lost, and that the inputs are stable at each clock edge. They also assume that no two mark codes can match one window, which holds for the code set of R2. The stimulus drives `frm_vld`, `mark_bit`, `wr_timing` and `clr` only on falling clock edges. It never asserts `clr` together with a strobe. It builds legal code sequences bit by bit, including a block-sync run that arms checking. Between directed cases it adds pseudo-random frames with idle gaps and write-timing frames.

// File: rtl/tmk_pkg.sv
package tmk_pkg;
  localparam int WIN_W  = 9;
  localparam int BT_W   = 5;
  localparam int DT_W   = 9;
  localparam int RING_W = 7;
  localparam int NFLAG  = 9;

  localparam int F_EZ  = 0;
  localparam int F_BSP = 1;
  localparam int F_BEF = 2;
  localparam int F_BER = 3;
  localparam int F_BSY = 4;
  localparam int F_DSY = 5;
  localparam int F_DEF = 6;
  localparam int F_DER = 7;
  localparam int F_DAT = 8;

  localparam logic [WIN_W-1:0] C_END_ZONE = 9'o622;
  localparam logic [WIN_W-1:0] C_SPC_MASK = 9'o477;
  localparam logic [WIN_W-1:0] C_SPC_VAL  = 9'o425;
  localparam logic [WIN_W-1:0] C_BEND_F   = 9'o526;
  localparam logic [WIN_W-1:0] C_BEND_R   = 9'o545;
  localparam logic [WIN_W-1:0] C_BSYNC    = 9'o751;
  localparam logic [WIN_W-1:0] C_DSYNC    = 9'o632;
  localparam logic [WIN_W-1:0] C_DEND_F0  = 9'o473;
  localparam logic [WIN_W-1:0] C_DEND_F1  = 9'o773;
  localparam logic [WIN_W-1:0] C_DEND_R0  = 9'o410;
  localparam logic [WIN_W-1:0] C_DEND_R1  = 9'o610;
  localparam logic [WIN_W-1:0] C_DATA     = 9'o470;

  typedef logic [NFLAG-1:0] mark_vec_t;
endpackage

// File: rtl/tmk_window.sv
module tmk_window
  import tmk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             hold,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_q,
  output logic [WIN_W-1:0] win_nxt
);
  always_comb begin
    if (hold)
      win_nxt = win_q;
    else
      win_nxt = {win_q[WIN_W-1] | win_q[WIN_W-2], win_q[WIN_W-3:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      win_q <= '0;
    else if (step)
      win_q <= win_nxt;
  end

  AST_TOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q[WIN_W-1] && !clr) |=> win_q[WIN_W-1]); // R1
  AST_HOLD_IN_WRT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold && !clr) |=> $stable(win_q)); // R9
  AST_IDLE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(win_q)); // R11
endmodule

// File: rtl/tmk_decode.sv
module tmk_decode
  import tmk_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output mark_vec_t        flags,
  output logic             any_mark
);
  always_comb begin
    flags        = '0;
    flags[F_EZ]  = (win == C_END_ZONE);
    flags[F_BSP] = ((win & C_SPC_MASK) == C_SPC_VAL);
    flags[F_BEF] = (win == C_BEND_F);
    flags[F_BER] = (win == C_BEND_R);
    flags[F_BSY] = (win == C_BSYNC);
    flags[F_DSY] = (win == C_DSYNC);
    flags[F_DEF] = (win == C_DEND_F0) || (win == C_DEND_F1);
    flags[F_DER] = (win == C_DEND_R0) || (win == C_DEND_R1);
    flags[F_DAT] = (win == C_DATA);
  end

  // marks that the check ring expects; block space and reverse block end excluded
  assign any_mark = flags[F_EZ] | flags[F_BEF] | flags[F_BSY] | flags[F_DSY]
                  | flags[F_DEF] | flags[F_DER] | flags[F_DAT];
endmodule

// File: rtl/tmk_shifter.sv
module tmk_shifter #(
  parameter int W       = 5,
  parameter int SEED    = 4,
  parameter bit OR_SEED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         seed,
  input  logic         shift,
  output logic         lsb_nxt,
  output logic [W-1:0] rise
);
  localparam logic [W-1:0] SEED_V = {{(W-1){1'b0}}, 1'b1} << SEED;

  logic [W-1:0] q;
  logic [W-1:0] seeded;
  logic [W-1:0] nxt;

  generate
    if (OR_SEED) begin : g_or
      assign seeded = seed ? (q | SEED_V) : q;
    end else begin : g_load
      assign seeded = seed ? SEED_V : q;
    end
  endgenerate

  assign nxt     = shift ? (seeded >> 1) : seeded;
  assign lsb_nxt = nxt[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q    <= '0;
      rise <= '0;
    end else if (step) begin
      q    <= nxt;
      rise <= nxt & ~q;
    end else begin
      rise <= '0;
    end
  end

  AST_RISE_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & ~q) == '0); // R5
  AST_RISE_ONLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |-> $past(step)); // R11

  generate
    if (!OR_SEED) begin : g_chk_load
      AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q)); // R4
    end
  endgenerate
endmodule

// File: rtl/tmk_check.sv
module tmk_check
  import tmk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic is_space,
  input  logic is_sync,
  input  logic any_mark,
  input  logic tb_lsb_nxt,
  output logic err
);
  localparam logic [RING_W-1:0] ONE    = {{(RING_W-1){1'b0}}, 1'b1};
  localparam logic [RING_W-1:0] RELOAD = ONE << (RING_W - 1);
  localparam logic [RING_W-1:0] PRESET = ONE << (RING_W - 2);

  logic [RING_W-1:0] ring_q, ring_sh, ring_nxt;
  logic              en_q, en_nxt;

  always_comb begin
    if (is_space)
      ring_sh = ring_q;
    else
      ring_sh = ((ring_q == ONE) ? RELOAD : ring_q) >> 1;
    ring_nxt = (tb_lsb_nxt && is_space) ? PRESET : ring_sh;

    en_nxt = en_q;
    if (tb_lsb_nxt && !is_space) en_nxt = 1'b1;
    if (is_sync)                 en_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ring_q <= '0;
      en_q   <= 1'b0;
      err    <= 1'b0;
    end else if (step) begin
      ring_q <= ring_nxt;
      en_q   <= en_nxt;
      err    <= en_q && ((ring_q == PRESET) != any_mark);
    end else begin
      err    <= 1'b0;
    end
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring_q)); // R6
  AST_SYNC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_sync && !clr) |=> !en_q); // R7
  AST_ERR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(en_q && step)); // R8
endmodule

// File: rtl/tape_mark_timing.sv
module tape_mark_timing
  import tmk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frm_vld,
  input  logic             mark_bit,
  input  logic             wr_timing,
  output logic [NFLAG-1:0] mark_flags,
  output logic [BT_W-1:0]  blk_edge,
  output logic [DT_W-1:0]  dat_edge,
  output logic             trk_err
);
  logic [WIN_W-1:0] win_q, win_nxt;
  mark_vec_t        fl_nxt;
  logic             any_mark;
  logic             blk_lsb_nxt, dat_lsb_nxt;

  tmk_window u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(frm_vld), .hold(wr_timing),
    .bit_in(mark_bit), .win_q(win_q), .win_nxt(win_nxt)
  );

  tmk_decode u_dec (.win(win_nxt), .flags(fl_nxt), .any_mark(any_mark));

  tmk_shifter #(.W(BT_W), .SEED(BT_W - 1), .OR_SEED(1'b1)) u_blk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(frm_vld),
    .seed(fl_nxt[F_BSY]), .shift(fl_nxt[F_BSY] | fl_nxt[F_BSP]),
    .lsb_nxt(blk_lsb_nxt), .rise(blk_edge)
  );

  tmk_shifter #(.W(DT_W), .SEED(DT_W - 1), .OR_SEED(1'b0)) u_dat (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(frm_vld),
    .seed(fl_nxt[F_DSY]),
    .shift(fl_nxt[F_DSY] | fl_nxt[F_DEF] | fl_nxt[F_DER]),
    .lsb_nxt(dat_lsb_nxt), .rise(dat_edge)
  );

  tmk_check u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(frm_vld),
    .is_space(fl_nxt[F_BSP]), .is_sync(fl_nxt[F_BSY]), .any_mark(any_mark),
    .tb_lsb_nxt(blk_lsb_nxt), .err(trk_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      mark_flags <= '0;
    else if (frm_vld)
      mark_flags <= fl_nxt;
  end

  AST_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mark_flags)); // R2
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_vld && !clr) |=> $stable(mark_flags)); // R11
  AST_BLK_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !clr && !blk_lsb_nxt) |=> !blk_edge[0]); // R5
  AST_DAT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !clr && !dat_lsb_nxt) |=> !dat_edge[0]); // R5
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mark_flags == '0 && blk_edge == '0 && dat_edge == '0 && !trk_err)); // R10
endmodule

// File: tb/sim_tape_mark_timing.sv
module sim_tape_mark_timing;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       frm_vld = 1'b0;
  logic       mark_bit = 1'b0;
  logic       wr_timing = 1'b0;
  logic [8:0] mark_flags;
  logic [4:0] blk_edge;
  logic [8:0] dat_edge;
  logic       trk_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_mark_timing u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frm_vld(frm_vld), .mark_bit(mark_bit),
    .wr_timing(wr_timing), .mark_flags(mark_flags), .blk_edge(blk_edge),
    .dat_edge(dat_edge), .trk_err(trk_err)
  );

  typedef struct {
    logic [8:0] fl;
    logic [4:0] be;
    logic [8:0] de;
    logic       er;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   err_seen = 0;
  int   cyc = 0;
  logic pend = 1'b0;

  // reference state, built from the requirements
  logic [8:0] m_win = '0;
  logic [4:0] m_tbm = '0;
  logic [8:0] m_tdt = '0;
  logic [6:0] m_ring = '0;
  logic       m_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0o exp=%0o", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [8:0] mdec(input logic [8:0] w);
    logic [8:0] f;
    f    = '0;
    f[0] = (w == 9'o622);
    f[1] = ((w & 9'o477) == 9'o425);
    f[2] = (w == 9'o526);
    f[3] = (w == 9'o545);
    f[4] = (w == 9'o751);
    f[5] = (w == 9'o632);
    f[6] = (w == 9'o473) || (w == 9'o773);
    f[7] = (w == 9'o410) || (w == 9'o610);
    f[8] = (w == 9'o470);
    return f;
  endfunction

  // driver: one frame, expected result pushed to the scoreboard
  task automatic frame(input logic b, input logic w, input string tag);
    exp_t       e;
    logic [8:0] wn, fl, ts, tn;
    logic [4:0] bs, bn;
    logic [6:0] rn;
    logic       sp, sy, vm;
    @(negedge clk);
    frm_vld = 1'b1; mark_bit = b; wr_timing = w;
    wn = w ? m_win : {m_win[8] | m_win[7], m_win[6:0], b};
    fl = mdec(wn);
    sp = fl[1]; sy = fl[4];
    bs = sy ? (m_tbm | 5'o20) : m_tbm;
    bn = (sy || sp) ? (bs >> 1) : bs;
    ts = fl[5] ? 9'o400 : m_tdt;
    tn = (fl[5] || fl[6] || fl[7]) ? (ts >> 1) : ts;
    vm = fl[0] | fl[2] | fl[4] | fl[5] | fl[6] | fl[7] | fl[8];
    e.fl = fl; e.be = bn & ~m_tbm; e.de = tn & ~m_tdt;
    e.er = m_en && ((m_ring == 7'o40) != vm);
    e.tag = tag;
    rn = m_ring;
    if (!sp) rn = ((rn == 7'o1) ? 7'o100 : rn) >> 1;
    if (bn[0] && sp) rn = 7'o40;
    if (bn[0] && !sp) m_en = 1'b1;
    if (sy) m_en = 1'b0;
    m_ring = rn; m_win = wn; m_tbm = bn; m_tdt = tn;
    sb.push_back(e);
    @(negedge clk);
    frm_vld = 1'b0; wr_timing = 1'b0;
  endtask

  task automatic do_clear(input string tag);
    exp_t e;
    @(negedge clk);
    clr = 1'b1;
    e.fl = '0; e.be = '0; e.de = '0; e.er = 1'b0; e.tag = tag;
    m_win = '0; m_tbm = '0; m_tdt = '0; m_ring = '0; m_en = 1'b0;
    sb.push_back(e);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic push_code(input logic [8:0] c, input string tag);
    for (int i = 8; i >= 0; i--) frame(c[i], 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk) pend <= frm_vld | clr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (trk_err) err_seen++;
      if (pend) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "unexpected result", 16'(mark_flags), 16'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(mark_flags == e.fl, "R2", {"flags case ", e.tag}, 16'(mark_flags), 16'(e.fl));
          chk(blk_edge == e.be, "R3", {"blk_edge case ", e.tag}, 16'(blk_edge), 16'(e.be));
          chk(dat_edge == e.de, "R4", {"dat_edge case ", e.tag}, 16'(dat_edge), 16'(e.de));
          chk(trk_err == e.er, "R8", {"trk_err case ", e.tag}, 16'(trk_err), 16'(e.er));
        end
      end else begin
        chk(blk_edge == '0 && dat_edge == '0 && !trk_err, "R11", "pulse without strobe",
            {blk_edge, dat_edge, trk_err, 1'b0}, 16'h0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  initial begin
    logic [15:0] lf;
    logic [8:0]  codes [12];
    int          idx [12];
    codes = '{9'o622, 9'o526, 9'o545, 9'o751, 9'o632, 9'o473,
              9'o773, 9'o410, 9'o610, 9'o470, 9'o425, 9'o625};
    idx   = '{0, 2, 3, 4, 5, 6, 6, 7, 7, 8, 1, 1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(mark_flags == '0, "R10", "flags after reset", 16'(mark_flags), 16'h0);
    chk(blk_edge == '0 && dat_edge == '0 && !trk_err, "R10", "pulses after reset",
        {blk_edge, dat_edge, trk_err, 1'b0}, 16'h0);

    // R1 R2: each code built bit by bit; sticky top keeps bit 8
    for (int k = 0; k < 12; k++) begin
      push_code(codes[k], "R1");
      chk(mark_flags == (9'h1 << idx[k]), "R2", "code decode", 16'(mark_flags),
          16'(9'h1 << idx[k]));
    end

    // R3 R5 R6 R7: block sync, three block spaces, then arm and see errors
    do_clear("R10");
    chk(mark_flags == '0, "R10", "flags after clear", 16'(mark_flags), 16'h0);
    frame(1, 0, "R3"); frame(1, 0, "R3"); frame(1, 0, "R3"); frame(1, 0, "R3");
    frame(0, 0, "R3"); frame(1, 0, "R3"); frame(0, 0, "R3"); frame(0, 0, "R3");
    frame(1, 0, "R3");
    chk(blk_edge == 5'o10, "R3", "block sync edge", 16'(blk_edge), 16'o10);
    frame(0, 0, "R5"); frame(1, 0, "R5"); frame(0, 0, "R5"); frame(1, 0, "R5");
    chk(blk_edge == 5'o04, "R5", "first block space edge", 16'(blk_edge), 16'o04);
    frame(0, 0, "R5"); frame(1, 0, "R5"); frame(0, 0, "R6"); frame(1, 0, "R6");
    chk(blk_edge == 5'o01, "R6", "last block space edge", 16'(blk_edge), 16'o01);
    err_seen = 0;
    repeat (24) frame(0, 0, "R7");
    chk(err_seen > 0, "R7", "armed ring reports missing mark", 16'(err_seen), 16'h1);

    // R4: data sync then forward data end
    do_clear("R10");
    push_code(9'o632, "R4");
    chk(dat_edge == 9'o200, "R4", "data sync edge", 16'(dat_edge), 16'o200);
    push_code(9'o473, "R4");
    chk(dat_edge == 9'o100, "R4", "data end edge", 16'(dat_edge), 16'o100);

    // R9: write-timing frames leave the window alone
    repeat (5) frame(1, 1, "R9");
    chk(mark_flags == 9'o100, "R9", "window held in write timing", 16'(mark_flags), 16'o100);

    // R10: clear mid-stream
    do_clear("R10");
    chk(mark_flags == '0, "R10", "flags after mid clear", 16'(mark_flags), 16'h0);

    // pseudo-random frames with gaps and write-timing
    lf = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      frame(lf[0], lf[5] & lf[9] & lf[3], "R1");
      if (lf[7] & lf[2]) @(negedge clk);
      if (n % 400 == 399) do_clear("R10");
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "scoreboard drained", 16'(sb.size()), 16'h0);
    summary();
  end
endmodule